// File: doc/BRIEF.md
# Dual Smart Card Signal Router

This block sits between a host controller and two smart card contact sets, A and B. It carries the host's reset, C4 and C8 control lines and the open-drain I/O data line to each card. It works in one of two modes. In split mode, each card port has its own set of host lines, and both cards run at the same time. In shared mode, only the port-A host lines are used. They reach whichever card the card-select input chooses, and the port-B host inputs are ignored.

Each card's outputs stop following the host when that card is not currently allowed to transact. This happens when the chip-select input is high (unselected), when the program input is low, or, in shared mode only, when the other card is selected. While frozen, each output keeps the value it last presented. A supply-low flag, or a card's own supply start-up flag, drives that card's control outputs to zero and pulls its I/O line low. The I/O line is modelled as an input level plus a drive-low enable on each side. The block also produces two pull-up enable flags for the host side.

Top module: `sc_dual_router`

## Requirements
- R1: In shared mode (mux_mode=1) with card_sel=1, card A's reset, C4 and C8 outputs follow the port-A host lines in the same cycle.
- R2: In shared mode with card_sel=0, card B's control outputs follow the port-A host lines, and the port-B host control inputs have no effect on any output.
- R3: In split mode (mux_mode=0), card A follows the port-A host lines and card B follows the port-B host lines, both at once.
- R4: In shared mode, pu_io_a is 0 and pu_b is 1 whatever pu_en is. In split mode, both flags equal pu_en.
- R5: In shared mode, the deselected card (A when card_sel=0, B when card_sel=1) keeps the control values it presented at the last clock edge before deselection. It follows the live lines again in the cycle it is reselected.
- R6: While cs_n=1, both cards' control outputs, including reset, keep the value they had at the last edge with cs_n=0. They follow again in the cycle cs_n returns to 0.
- R7: While prog_n=0, both cards' control outputs keep their last value, exactly as for R6.
- R8: supply_low=1 forces the control outputs of both cards to 0 and asserts both card I/O drive-low enables. startup_a=1 or startup_b=1 does the same for its own card only. All of this takes effect in the same cycle.
- R9: One clock edge after a routed host I/O input goes low from idle, the card's I/O drive-low enable asserts. It releases one edge after the host input returns high.
- R10: One clock edge after a card's I/O input goes low from idle, the host drive-low enable asserts on the host port routed to that card (port A in shared mode). It releases one edge after the card input returns high.
- R11: While cs_n=1, the I/O drive state of each link is frozen. It resumes tracking at the first edge after cs_n returns to 0.
- R12: A synchronous active-low reset clears all held control values to 0 and sets every I/O link idle, so that all drive-low enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mux_mode | input | 1 | 1 = shared mode, 0 = split mode |
| card_sel | input | 1 | Shared-mode target: 1 = card A, 0 = card B |
| cs_n | input | 1 | Chip select, active low |
| prog_n | input | 1 | Program mode when low |
| pu_en | input | 1 | Requested host pull-up enable |
| supply_low | input | 1 | Supply undervoltage flag |
| startup_a | input | 1 | Card A supply start-up in progress |
| startup_b | input | 1 | Card B supply start-up in progress |
| h_rst_a | input | 1 | Host reset line, port A |
| h_c4_a | input | 1 | Host C4 line, port A |
| h_c8_a | input | 1 | Host C8 line, port A |
| h_io_a_in | input | 1 | Host I/O level, port A |
| h_io_a_oe | output | 1 | Drive host I/O A low |
| h_rst_b | input | 1 | Host reset line, port B |
| h_c4_b | input | 1 | Host C4 line, port B |
| h_c8_b | input | 1 | Host C8 line, port B |
| h_io_b_in | input | 1 | Host I/O level, port B |
| h_io_b_oe | output | 1 | Drive host I/O B low |
| k_rst_a | output | 1 | Card A reset |
| k_c4_a | output | 1 | Card A C4 |
| k_c8_a | output | 1 | Card A C8 |
| k_io_a_in | input | 1 | Card A I/O level |
| k_io_a_oe | output | 1 | Drive card A I/O low |
| k_rst_b | output | 1 | Card B reset |
| k_c4_b | output | 1 | Card B C4 |
| k_c8_b | output | 1 | Card B C8 |
| k_io_b_in | input | 1 | Card B I/O level |
| k_io_b_oe | output | 1 | Drive card B I/O low |
| pu_io_a | output | 1 | Pull-up enable for host I/O A |
| pu_b | output | 1 | Pull-up enable for the port-B host lines |

## Verification
The bench goes after the moment a card becomes frozen. A design that sampled the hold register one cycle late, or that let the freshly changed host value leak through, would show the new value instead of the one presented at the last edge. Shared mode is checked by wiggling the port-B host lines while card B is routed from port A; a router that still listened to port B would pass those changes through. The force-low override is applied on top of live traffic and on one card only, which exposes a design that forces both cards on one start-up flag or that registers the override. The I/O checks count edges to catch the wrong latency, a drive on the wrong host port in shared mode, and a link that keeps tracking while chip-select is high.

// File: rtl/sc_router_pkg.sv
package sc_router_pkg;
  // Control bit packing used inside the router: [0]=reset, [1]=C4, [2]=C8
  localparam int CTL_W = 3;
  typedef logic [CTL_W-1:0] ctl_t;

  // Owner of the low level on an open-drain I/O link
  typedef enum logic [1:0] {
    LNK_IDLE     = 2'd0,
    LNK_HOST_LOW = 2'd1,
    LNK_CARD_LOW = 2'd2
  } link_own_t;

  function automatic ctl_t pack_ctl(input logic rst, input logic c4, input logic c8);
    return {c8, c4, rst};
  endfunction

  // Card index 0 = A, 1 = B. Freeze when unselected, programming, or shared-mode deselected.
  function automatic logic freeze_card(input logic idx_b, input logic mux, input logic sel,
                                       input logic csn, input logic progn);
    logic desel;
    desel = mux & (idx_b ? sel : ~sel);
    return csn | ~progn | desel;
  endfunction
endpackage

// File: rtl/sc_hold_lane.sv
module sc_hold_lane #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         force_low,
  input  logic [W-1:0] live,
  output logic [W-1:0] out
);
  logic [W-1:0] held_q;

  always_comb begin
    if (force_low)  out = '0;
    else if (hold)  out = held_q;
    else            out = live;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     held_q <= '0;
    else if (!hold) held_q <= out;
  end
endmodule

// File: rtl/sc_io_link.sv
module sc_io_link
  import sc_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic force_low,
  input  logic host_in,
  input  logic card_in,
  output logic card_oe,
  output logic host_oe
);
  link_own_t own_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         own_q <= LNK_IDLE;
    else if (force_low) own_q <= LNK_IDLE;
    else if (!hold) begin
      unique case (own_q)
        LNK_IDLE: begin
          if (!host_in)      own_q <= LNK_HOST_LOW;
          else if (!card_in) own_q <= LNK_CARD_LOW;
        end
        LNK_HOST_LOW: if (host_in) own_q <= LNK_IDLE;
        LNK_CARD_LOW: if (card_in) own_q <= LNK_IDLE;
        default: own_q <= LNK_IDLE;
      endcase
    end
  end

  assign card_oe = force_low | (own_q == LNK_HOST_LOW);
  assign host_oe = ~force_low & (own_q == LNK_CARD_LOW);
endmodule

// File: rtl/sc_dual_router.sv
module sc_dual_router
  import sc_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mux_mode,
  input  logic card_sel,
  input  logic cs_n,
  input  logic prog_n,
  input  logic pu_en,
  input  logic supply_low,
  input  logic startup_a,
  input  logic startup_b,
  input  logic h_rst_a,
  input  logic h_c4_a,
  input  logic h_c8_a,
  input  logic h_io_a_in,
  output logic h_io_a_oe,
  input  logic h_rst_b,
  input  logic h_c4_b,
  input  logic h_c8_b,
  input  logic h_io_b_in,
  output logic h_io_b_oe,
  output logic k_rst_a,
  output logic k_c4_a,
  output logic k_c8_a,
  input  logic k_io_a_in,
  output logic k_io_a_oe,
  output logic k_rst_b,
  output logic k_c4_b,
  output logic k_c8_b,
  input  logic k_io_b_in,
  output logic k_io_b_oe,
  output logic pu_io_a,
  output logic pu_b
);
  localparam int NCARD = 2;

  ctl_t       live_ctl [NCARD];
  ctl_t       card_ctl [NCARD];
  logic [NCARD-1:0] hold_v, force_v, link_hin, link_kin, link_koe, link_hoe;

  // Named internal events for the checker
  logic hold_a, hold_b, force_a, force_b, link_hoe_a, link_hoe_b;

  ctl_t host_a_ctl, host_b_ctl;
  assign host_a_ctl = pack_ctl(h_rst_a, h_c4_a, h_c8_a);
  assign host_b_ctl = pack_ctl(h_rst_b, h_c4_b, h_c8_b);

  // Routing: card A always from port A; card B from port A in shared mode
  assign live_ctl[0] = host_a_ctl;
  assign live_ctl[1] = mux_mode ? host_a_ctl : host_b_ctl;
  assign link_hin[0] = h_io_a_in;
  assign link_hin[1] = mux_mode ? h_io_a_in : h_io_b_in;
  assign link_kin[0] = k_io_a_in;
  assign link_kin[1] = k_io_b_in;

  assign force_v[0] = supply_low | startup_a;
  assign force_v[1] = supply_low | startup_b;

  for (genvar g = 0; g < NCARD; g++) begin : g_card
    assign hold_v[g] = freeze_card(g[0], mux_mode, card_sel, cs_n, prog_n);

    sc_hold_lane #(.W(CTL_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold_v[g]),
      .force_low(force_v[g]),
      .live     (live_ctl[g]),
      .out      (card_ctl[g])
    );

    sc_io_link u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold_v[g]),
      .force_low(force_v[g]),
      .host_in  (link_hin[g]),
      .card_in  (link_kin[g]),
      .card_oe  (link_koe[g]),
      .host_oe  (link_hoe[g])
    );
  end

  assign hold_a     = hold_v[0];
  assign hold_b     = hold_v[1];
  assign force_a    = force_v[0];
  assign force_b    = force_v[1];
  assign link_hoe_a = link_hoe[0];
  assign link_hoe_b = link_hoe[1];

  assign {k_c8_a, k_c4_a, k_rst_a} = card_ctl[0];
  assign {k_c8_b, k_c4_b, k_rst_b} = card_ctl[1];
  assign k_io_a_oe = link_koe[0];
  assign k_io_b_oe = link_koe[1];

  // Host drive-low: port A sees whichever card it is routed to
  assign h_io_a_oe = (mux_mode && !card_sel) ? link_hoe_b : link_hoe_a;
  assign h_io_b_oe = mux_mode ? 1'b0 : link_hoe_b;

  assign pu_io_a = mux_mode ? 1'b0 : pu_en;
  assign pu_b    = mux_mode ? 1'b1 : pu_en;
endmodule

// File: rtl/sc_dual_router_chk.sv
module sc_dual_router_chk (
  input logic clk,
  input logic rst_n,
  input logic mux_mode,
  input logic pu_en,
  input logic h_rst_a, input logic h_c4_a, input logic h_c8_a,
  input logic h_rst_b, input logic h_c4_b, input logic h_c8_b,
  input logic k_rst_a, input logic k_c4_a, input logic k_c8_a,
  input logic k_rst_b, input logic k_c4_b, input logic k_c8_b,
  input logic k_io_a_oe, input logic k_io_b_oe,
  input logic pu_io_a, input logic pu_b,
  input logic hold_a, input logic hold_b,
  input logic force_a, input logic force_b,
  input logic link_hoe_a, input logic link_hoe_b
);
  // R3
  split_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_mode && !hold_a && !force_a && !hold_b && !force_b) |->
      ({k_rst_a, k_c4_a, k_c8_a} == {h_rst_a, h_c4_a, h_c8_a}) &&
      ({k_rst_b, k_c4_b, k_c8_b} == {h_rst_b, h_c4_b, h_c8_b}));

  // R4
  shared_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_mode |-> (pu_b && !pu_io_a));

  // R4
  split_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_mode |-> (pu_b == pu_en) && (pu_io_a == pu_en));

  // R6
  hold_a_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_a && $past(hold_a) && !force_a && !$past(force_a)) |->
      $stable({k_rst_a, k_c4_a, k_c8_a}));

  // R7
  hold_b_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_b && $past(hold_b) && !force_b && !$past(force_b)) |->
      $stable({k_rst_b, k_c4_b, k_c8_b}));

  // R8
  force_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_a |-> ({k_rst_a, k_c4_a, k_c8_a} == 3'b000) && k_io_a_oe);

  // R8
  force_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_b |-> ({k_rst_b, k_c4_b, k_c8_b} == 3'b000) && k_io_b_oe);

  // R9
  link_dir_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({k_io_a_oe, link_hoe_a}));

  // R10
  link_dir_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({k_io_b_oe, link_hoe_b}));
endmodule

bind sc_dual_router sc_dual_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .pu_en(pu_en),
  .h_rst_a(h_rst_a), .h_c4_a(h_c4_a), .h_c8_a(h_c8_a),
  .h_rst_b(h_rst_b), .h_c4_b(h_c4_b), .h_c8_b(h_c8_b),
  .k_rst_a(k_rst_a), .k_c4_a(k_c4_a), .k_c8_a(k_c8_a),
  .k_rst_b(k_rst_b), .k_c4_b(k_c4_b), .k_c8_b(k_c8_b),
  .k_io_a_oe(k_io_a_oe), .k_io_b_oe(k_io_b_oe),
  .pu_io_a(pu_io_a), .pu_b(pu_b),
  .hold_a(hold_a), .hold_b(hold_b),
  .force_a(force_a), .force_b(force_b),
  .link_hoe_a(link_hoe_a), .link_hoe_b(link_hoe_b)
);

// File: tb/tb_sc_dual_router.sv
`timescale 1ns/100ps
module tb_sc_dual_router;
  logic clk = 1'b0;
  logic rst_n, mux_mode, card_sel, cs_n, prog_n, pu_en, supply_low, startup_a, startup_b;
  logic h_rst_a, h_c4_a, h_c8_a, h_io_a_in, h_io_a_oe;
  logic h_rst_b, h_c4_b, h_c8_b, h_io_b_in, h_io_b_oe;
  logic k_rst_a, k_c4_a, k_c8_a, k_io_a_in, k_io_a_oe;
  logic k_rst_b, k_c4_b, k_c8_b, k_io_b_in, k_io_b_oe;
  logic pu_io_a, pu_b;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sc_dual_router dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Host control written as {c8,c4,rst}
  task automatic set_a(input logic [2:0] v); {h_c8_a, h_c4_a, h_rst_a} = v; endtask
  task automatic set_b(input logic [2:0] v); {h_c8_b, h_c4_b, h_rst_b} = v; endtask
  function automatic logic [7:0] card_a(); return {5'd0, k_c8_a, k_c4_a, k_rst_a}; endfunction
  function automatic logic [7:0] card_b(); return {5'd0, k_c8_b, k_c4_b, k_rst_b}; endfunction

  task automatic t_reset();
    rst_n = 1'b0; mux_mode = 0; card_sel = 1; cs_n = 0; prog_n = 1; pu_en = 0;
    supply_low = 0; startup_a = 0; startup_b = 0;
    set_a(3'b000); set_b(3'b000);
    h_io_a_in = 1; h_io_b_in = 1; k_io_a_in = 1; k_io_b_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cs_n = 1;
    #1;
    chk("R12 card A ctl", card_a(), 8'd0);
    chk("R12 card B ctl", card_b(), 8'd0);
    chk("R12 drive enables", {4'd0, k_io_a_oe, k_io_b_oe, h_io_a_oe, h_io_b_oe}, 8'd0);
    @(negedge clk); cs_n = 0;
  endtask

  task automatic t_split();
    mux_mode = 0; set_a(3'b101); set_b(3'b010); #1;
    chk("R3 card A", card_a(), 8'h5);
    chk("R3 card B", card_b(), 8'h2);
    set_a(3'b011); set_b(3'b110); #1;
    chk("R3 card A p2", card_a(), 8'h3);
    chk("R3 card B p2", card_b(), 8'h6);
    @(negedge clk);
  endtask

  task automatic t_shared();
    mux_mode = 1; card_sel = 1; set_a(3'b110); set_b(3'b001); #1;
    chk("R1 card A from port A", card_a(), 8'h6);
    @(negedge clk);
    card_sel = 0; set_a(3'b011); set_b(3'b100); #1;
    chk("R2 card B from port A", card_b(), 8'h3);
    chk("R5 card A held on deselect", card_a(), 8'h6);
    set_b(3'b111); #1;
    chk("R2 port B ignored", card_b(), 8'h3);
    chk("R2 port B ignored, card A", card_a(), 8'h6);
    @(negedge clk);
    chk("R5 card A still held", card_a(), 8'h6);
    card_sel = 1; #1;
    chk("R5 card A resumes", card_a(), 8'h3);
    chk("R5 card B held", card_b(), 8'h3);
    set_a(3'b100); #1;
    chk("R5 card B held after change", card_b(), 8'h3);
    @(negedge clk);
  endtask

  task automatic t_pullup();
    mux_mode = 1; pu_en = 0; #1;
    chk("R4 shared pu_en=0", {6'd0, pu_io_a, pu_b}, 8'h1);
    pu_en = 1; #1;
    chk("R4 shared pu_en=1", {6'd0, pu_io_a, pu_b}, 8'h1);
    mux_mode = 0; #1;
    chk("R4 split pu_en=1", {6'd0, pu_io_a, pu_b}, 8'h3);
    pu_en = 0; #1;
    chk("R4 split pu_en=0", {6'd0, pu_io_a, pu_b}, 8'h0);
    @(negedge clk);
  endtask

  task automatic t_freeze(input bit use_prog);
    string tg;
    tg = use_prog ? "R7" : "R6";
    mux_mode = 0; set_a(3'b111); set_b(3'b101);
    @(negedge clk);
    if (use_prog) prog_n = 0; else cs_n = 1;
    set_a(3'b000); set_b(3'b010); #1;
    chk({tg, " card A frozen"}, card_a(), 8'h7);
    chk({tg, " card B frozen"}, card_b(), 8'h5);
    @(negedge clk);
    chk({tg, " card A frozen next"}, card_a(), 8'h7);
    prog_n = 1; cs_n = 0; #1;
    chk({tg, " card A resumes"}, card_a(), 8'h0);
    chk({tg, " card B resumes"}, card_b(), 8'h2);
    @(negedge clk);
  endtask

  task automatic t_force();
    mux_mode = 0; set_a(3'b111); set_b(3'b111); startup_a = 1; #1;
    chk("R8 startup A card A", card_a(), 8'h0);
    chk("R8 startup A card B untouched", card_b(), 8'h7);
    chk("R8 startup A io", {6'd0, k_io_a_oe, k_io_b_oe}, 8'h2);
    startup_a = 0; supply_low = 1; #1;
    chk("R8 supply low both", {card_a()[3:0], card_b()[3:0]}, 8'h0);
    chk("R8 supply low io", {6'd0, k_io_a_oe, k_io_b_oe}, 8'h3);
    supply_low = 0; startup_b = 1; #1;
    chk("R8 startup B", {card_a()[3:0], card_b()[3:0]}, 8'h70);
    startup_b = 0;
    @(negedge clk);
    chk("R8 released io", {6'd0, k_io_a_oe, k_io_b_oe}, 8'h0);
  endtask

  task automatic t_io_split();
    mux_mode = 0; h_io_a_in = 0; #1;
    chk("R9 no drive before edge", {7'd0, k_io_a_oe}, 8'h0);
    @(negedge clk);
    chk("R9 card A driven low", {6'd0, k_io_a_oe, h_io_a_oe}, 8'h2);
    h_io_a_in = 1; @(negedge clk);
    chk("R9 card A released", {7'd0, k_io_a_oe}, 8'h0);
    k_io_b_in = 0; @(negedge clk);
    chk("R10 host B driven low", {6'd0, h_io_b_oe, k_io_b_oe}, 8'h2);
    k_io_b_in = 1; @(negedge clk);
    chk("R10 host B released", {7'd0, h_io_b_oe}, 8'h0);
  endtask

  task automatic t_io_shared();
    mux_mode = 1; card_sel = 0; k_io_b_in = 0; @(negedge clk);
    chk("R10 shared host A drives for card B", {6'd0, h_io_a_oe, h_io_b_oe}, 8'h2);
    k_io_b_in = 1; @(negedge clk);
    chk("R10 shared released", {7'd0, h_io_a_oe}, 8'h0);
    h_io_a_in = 0; @(negedge clk);
    chk("R9 shared card B driven", {6'd0, k_io_b_oe, k_io_a_oe}, 8'h2);
    h_io_a_in = 1; card_sel = 1; @(negedge clk);
  endtask

  task automatic t_io_hold();
    mux_mode = 0; h_io_a_in = 0; @(negedge clk);
    chk("R11 link active", {7'd0, k_io_a_oe}, 8'h1);
    cs_n = 1; h_io_a_in = 1; @(negedge clk);
    chk("R11 drive frozen", {7'd0, k_io_a_oe}, 8'h1);
    @(negedge clk);
    chk("R11 drive frozen two", {7'd0, k_io_a_oe}, 8'h1);
    cs_n = 0; #1;
    chk("R11 still set before edge", {7'd0, k_io_a_oe}, 8'h1);
    @(negedge clk);
    chk("R11 resumed", {7'd0, k_io_a_oe}, 8'h0);
  endtask

  initial begin
    t_reset();
    t_split();
    t_shared();
    t_pullup();
    t_freeze(1'b0);
    t_freeze(1'b1);
    t_force();
    t_io_split();
    t_io_shared();
    t_io_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule